// File: doc/BRIEF.md
# Four-Phase Handshake Word Bridge

This block carries one data word at a time from a source clock domain into a destination clock domain. The two clocks have no fixed relation. Only two single-bit control lines cross the boundary: a request line that goes from source to destination, and an acknowledge line that comes back. Each passes through its own chain of synchronizer flops. The data word is never synchronized bit by bit. The sender registers the word and keeps it frozen while the request is raised. The receiver takes the whole word in one edge, in the cycle where its synchronized copy of the request first reads high. That single edge is the point of synchronization for the transfer.

Every transfer makes a full return-to-zero cycle. The request rises, then the acknowledge rises, then the request falls, then the acknowledge falls. The sender accepts the next word only after it has seen the acknowledge low again.

The source port is a valid/ready stream. A word is accepted on a source clock edge where `src_valid` and `src_ready` are both high. `src_ready` is low for the whole handshake, so back-pressure on the source side lasts one full round trip per word. The destination side has no back-pressure. The receiver gets a one-cycle strobe and must take the word in that cycle. The word then stays on `dst_data` until the next strobe. `src_busy` is a plain status pin and is always the inverse of `src_ready`.

Top module: `xdom_word_bridge`

## Requirements
- R1: While its reset is held, and after reset before any transfer, the source side shows `src_ready`=1 and `src_busy`=0, and the destination side shows `dst_valid`=0 and `dst_data`=0.
- R2: A word is accepted on a source edge where `src_valid`=1 and `src_ready`=1. At every source cycle, `src_ready` equals the inverse of `src_busy`.
- R3: `src_busy` is 1 from the source cycle after an acceptance until the returned acknowledge has been seen low again. It then returns to 0 within a bounded number of source cycles.
- R4: A `src_valid` presented while `src_busy`=1 is ignored. It causes no delivery, and the held word does not change.
- R5: Every accepted word appears unchanged on `dst_data`, and words appear in the order they were accepted.
- R6: Each transfer raises `dst_valid` for exactly one destination cycle.
- R7: The request is raised only while the returned acknowledge reads low, and it is dropped only after that acknowledge reads high. A transfer therefore keeps the source busy for at least 4 source cycles.
- R8: The word driven across the boundary stays constant for as long as the request is high, whatever `src_data` does after acceptance.
- R9: The acknowledge rises in the same destination cycle as the `dst_valid` strobe. The strobe therefore occurs while the source is still busy.
- R10: Between strobes, `dst_data` holds the last delivered word.
- R11: The strobe for a word follows its acceptance by no more than a few destination cycles, set by the synchronizer depth. The bench bound is 100 ns for the default depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Bridge can accept a word (idle) |
| src_data | input | DATA_W | Word offered by the source |
| src_busy | output | 1 | Handshake in progress |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_valid | output | 1 | One-cycle strobe: a new word is on `dst_data` |
| dst_data | output | DATA_W | Last delivered word |

## Verification
Some internal faults can only be seen at the ports. If the handshake state were wrong, for example a request dropped early or an acknowledge that never returns low, the source would either stay busy or release it too early. The bench would see this within a few source cycles of the acceptance, through the busy-duration bounds. A capture taken in the wrong cycle, or a held word that is allowed to move, shows up at the first strobe as a mismatched word. That mismatch is visible because the bench changes `src_data` right after each acceptance. A strobe that does not return to zero shows up one destination cycle later as a double delivery or a broken order.

// File: rtl/xwb_pkg.sv
package xwb_pkg;
  // phases of the sender: idle, request raised, request released
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAISE = 2'd1,
    PH_LOWER = 2'd2
  } ph_e;
endpackage

// File: rtl/xwb_sync.sv
module xwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/xwb_send.sv
module xwb_send
  import xwb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy_o,
  output logic              req_o,
  output logic [DATA_W-1:0] bus_o,
  input  logic              ack_i
);
  ph_e               phase;
  logic [DATA_W-1:0] hold;
  logic              req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      hold  <= '0;
      req_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (in_valid) begin
            hold  <= in_data;
            req_q <= 1'b1;
            phase <= PH_RAISE;
          end
        end
        PH_RAISE: begin
          if (ack_i) begin
            req_q <= 1'b0;
            phase <= PH_LOWER;
          end
        end
        PH_LOWER: begin
          if (!ack_i) phase <= PH_IDLE;
        end
        default: begin
          req_q <= 1'b0;
          phase <= PH_IDLE;
        end
      endcase
    end
  end

  assign in_ready = (phase == PH_IDLE);
  assign busy_o   = (phase != PH_IDLE);
  assign req_o    = req_q;
  assign bus_o    = hold;

  AST_REQ_RISE_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_i)); // R7
  AST_REQ_FALL_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(ack_i)); // R7
  AST_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> $stable(bus_o)); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_ready) |-> $stable(bus_o)); // R4
endmodule

// File: rtl/xwb_recv.sv
module xwb_recv #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic ack_q;
  logic take;

  assign take = req_i & ~ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      ack_q     <= req_i;
      out_valid <= take;
      if (take) out_data <= bus_i;
    end
  end

  assign ack_o = ack_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_ACK_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> out_valid); // R9
  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R10
endmodule

// File: rtl/xdom_word_bridge.sv
module xdom_word_bridge #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_busy,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_src;
  logic              req_dst;
  logic              ack_dst;
  logic              ack_src;
  logic [DATA_W-1:0] word_bus;

  xwb_send #(.DATA_W(DATA_W)) u_send (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .in_valid (src_valid),
    .in_data  (src_data),
    .in_ready (src_ready),
    .busy_o   (src_busy),
    .req_o    (req_src),
    .bus_o    (word_bus),
    .ack_i    (ack_src)
  );

  xwb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (req_src),
    .q     (req_dst)
  );

  xwb_recv #(.DATA_W(DATA_W)) u_recv (
    .clk       (dst_clk),
    .rst_n     (dst_rst_n),
    .req_i     (req_dst),
    .bus_i     (word_bus),
    .ack_o     (ack_dst),
    .out_valid (dst_valid),
    .out_data  (dst_data)
  );

  xwb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (ack_dst),
    .q     (ack_src)
  );

  AST_READY_NOT_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_ready != src_busy); // R2
endmodule

// File: tb/xdom_word_bridge_tb.sv
`timescale 1ns/100ps
module xdom_word_bridge_tb;
  localparam int W = 16;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst_n = 0, dst_rst_n = 0;
  logic         src_valid = 0;
  logic [W-1:0] src_data = '0;
  logic         src_ready, src_busy, dst_valid;
  logic [W-1:0] dst_data;

  always #4   src_clk = ~src_clk;
  always #5.5 dst_clk = ~dst_clk;

  xdom_word_bridge #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .src_busy(src_busy),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_valid(dst_valid),
    .dst_data(dst_data)
  );

  int           n_chk = 0, n_fail = 0;
  int           n_acc = 0, n_got = 0;
  logic [W-1:0] exp_q[$];
  time          t_q[$];
  logic [W-1:0] last_got = '0;
  logic         prev_v = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model of the destination side: queue of accepted words
  always @(negedge dst_clk) begin
    if (dst_rst_n && src_rst_n) begin
      if (dst_valid) begin
        chk(!prev_v, "R6 strobe longer than one cycle", prev_v, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected delivery", dst_data, 0);
        end else begin
          logic [W-1:0] e;
          time          t;
          e = exp_q.pop_front();
          t = t_q.pop_front();
          chk(dst_data == e, "R5/R8 delivered word", dst_data, e);
          chk(($time - t) <= 100, "R11 latency ns", $time - t, 100);
        end
        chk(src_busy == 1'b1, "R9 strobe while source busy", src_busy, 1);
        n_got++;
        last_got = dst_data;
      end else if (n_got > 0 && dst_data !== last_got) begin
        chk(0, "R10 data held between strobes", dst_data, last_got);
      end
      prev_v = dst_valid;
    end
  end

  // ready/busy relation checked every source cycle
  always @(negedge src_clk) begin
    if (src_rst_n && (src_ready !== ~src_busy))
      chk(0, "R2 ready vs busy", src_ready, ~src_busy);
  end

  task automatic send(input logic [W-1:0] w, input bit poke);
    bit acc;
    int dur;
    @(negedge src_clk);
    src_valid = 1;
    src_data  = w;
    acc = src_ready;
    if (acc) begin
      exp_q.push_back(w);
      t_q.push_back($time);
      n_acc++;
    end
    @(negedge src_clk);
    src_valid = 0;
    src_data  = ~w;                 // R8: source data moves right after acceptance
    if (acc) begin
      chk(src_busy == 1'b1, "R3 busy after accept", src_busy, 1);
      chk(src_ready == 1'b0, "R2 ready low after accept", src_ready, 0);
    end
    dur = 1;
    while (src_busy && dur < 60) begin
      if (poke) begin               // R4: offers while busy must be ignored
        src_valid = 1;
        src_data  = w ^ 16'h5A5A;
      end
      @(negedge src_clk);
      dur++;
    end
    src_valid = 0;
    if (acc) begin
      chk(dur >= 4, "R7 four-phase minimum busy cycles", dur, 4);
      chk(!src_busy, "R3 busy clears", src_busy, 0);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge src_clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge src_clk);
    chk(src_ready == 1'b1, "R1 ready in reset", src_ready, 1);
    chk(src_busy == 1'b0, "R1 busy in reset", src_busy, 0);
    chk(dst_valid == 1'b0, "R1 dst_valid in reset", dst_valid, 0);
    chk(dst_data == '0, "R1 dst_data in reset", dst_data, 0);
    @(negedge src_clk) src_rst_n = 1;
    @(negedge dst_clk) dst_rst_n = 1;
    repeat (3) @(negedge src_clk);
    chk(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
    chk(src_busy == 1'b0, "R1 busy after reset", src_busy, 0);
    chk(dst_valid == 1'b0, "R1 dst_valid after reset", dst_valid, 0);

    send(16'h0000, 0);
    send(16'hFFFF, 0);
    send(16'hA5A5, 1);
    send(16'h5A5A, 1);
    for (int i = 0; i < W; i++) send(16'(1) << i, i[0]);
    for (int i = 0; i < 8; i++) send(16'($urandom()), 1);

    repeat (40) @(negedge dst_clk);
    chk(n_got == n_acc, "R4/R5 delivery count", n_got, n_acc);
    chk(exp_q.size() == 0, "R5 nothing left pending", exp_q.size(), 0);
    chk(dst_data == last_got, "R10 final word held", dst_data, last_got);
    summary();
    $finish;
  end
endmodule